// File: doc/BRIEF.md
# Registered Burst Repeater

The block is a one-entry pipeline stage with a valid/stall handshake on each side. It accepts one data word together with a repeat count. It then presents that word on a registered output once for every output beat the consumer takes, until the requested number of beats has left. A beat on either side moves in a cycle where valid is high and stall is low.

The input side opens again in the same cycle that the final repeat is taken. A producer with a word waiting therefore lands it directly behind the previous burst, and no empty output cycle appears between bursts. A compile-time transform hook sits in the data path. It is applied to the incoming word when the word is captured, and again to the held word on each later accepted beat. The default hook passes data through unchanged. One alternative hook adds one to the word, which shows the re-application from beat to beat.

Top module: `burst_repeater`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` on the next rising edge, and the output stays empty until a word is accepted.
- R2: A word accepted on a rising edge (`in_valid` high, `in_stall` low) is presented on `out_data`, with `out_valid` high, in the following cycle. The latency is one clock.
- R3: A count value `c` on `in_cnt` (the number of beats minus one) produces exactly `c`+1 accepted output beats, so 0 gives a single beat and 15 gives sixteen beats.
- R4: While `out_valid` and `out_stall` are both high, `out_valid` and `out_data` keep their values on the next cycle, and the remaining beat count does not change.
- R5: `in_stall` is high while the output holds a word whose final beat is not being taken in the current cycle.
- R6: `in_stall` is low whenever `out_valid` is low.
- R7: In a cycle where the final beat of a burst is taken and `in_valid` is high, `in_stall` is low and the new word is accepted. `out_valid` stays high in the next cycle, with no bubble.
- R8: With the default hook (`XFORM` = `XF_PASS`), every beat of a burst shows the accepted input word unchanged.
- R9: With the increment hook (`XFORM` = `XF_INC`, adding 1 modulo 2^W), beat k of a burst (k counted from 0) shows the accepted word plus k+1.
- R10: When the final beat is taken and `in_valid` is low, `out_valid` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | W | Word to repeat |
| in_cnt | input | D | Number of output beats minus one |
| in_valid | input | 1 | Input word present |
| in_stall | output | 1 | Input cannot be accepted this cycle |
| out_data | output | W | Registered output word |
| out_valid | output | 1 | Output word present |
| out_stall | input | 1 | Consumer refuses the current beat |

## Verification
The properties put no constraint on `in_valid`, `in_cnt` or `out_stall`. They hold for any input pattern, provided reset has been applied once before the first word. The stimulus is a more disciplined producer: it holds each word and its count steady until the word is accepted, and it draws `out_stall` from a pseudo-random sequence at a density set per burst. This keeps every burst traceable beat by beat. Directed runs add zero-count bursts sent back to back, a full-range count with no stall, and a reset in the middle of a burst.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic [0:0] {
    XF_PASS = 1'b0,
    XF_INC  = 1'b1
  } xform_e;
endpackage

// File: rtl/rpt_xform.sv
module rpt_xform #(
  parameter int W = 32,
  parameter rpt_pkg::xform_e KIND = rpt_pkg::XF_PASS
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (KIND == rpt_pkg::XF_INC) begin : g_inc
      assign dout = din + {{(W-1){1'b0}}, 1'b1};
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/rpt_count.sv
module rpt_count #(
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [D-1:0] load_val,
  input  logic         take,
  output logic [D-1:0] cnt_q,
  output logic         at_zero
);
  localparam logic [D-1:0] ZERO = '0;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= ZERO;
    else if (load)
      cnt_q <= load_val;
    else
      cnt_q <= cnt_q - {{(D-1){1'b0}}, take};
  end

  assign at_zero = (cnt_q == ZERO);
endmodule

// File: rtl/rpt_hold.sv
module rpt_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         take,
  input  logic         more,
  input  logic         stall,
  input  logic [W-1:0] new_word,
  input  logic [W-1:0] next_word,
  output logic         valid_q,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)
      valid_q <= 1'b0;
    else
      valid_q <= load | (valid_q & (more | stall));
  end

  always_ff @(posedge clk) begin
    if (load)
      data_q <= new_word;
    else if (take)
      data_q <= next_word;
  end
endmodule

// File: rtl/burst_repeater.sv
module burst_repeater #(
  parameter int W = 32,
  parameter int D = 4,
  parameter rpt_pkg::xform_e XFORM = rpt_pkg::XF_PASS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_data,
  input  logic [D-1:0] in_cnt,
  input  logic         in_valid,
  output logic         in_stall,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_stall
);
  logic         take;
  logic         finish;
  logic         load;
  logic         at_zero;
  logic [D-1:0] cnt_q;
  logic [W-1:0] xf_in;
  logic [W-1:0] xf_held;

  assign take     = out_valid & ~out_stall;
  assign finish   = take & at_zero;
  assign in_stall = out_valid & ~finish;
  assign load     = in_valid & ~in_stall;

  rpt_xform #(.W(W), .KIND(XFORM)) u_xf_in (
    .din  (in_data),
    .dout (xf_in)
  );

  rpt_xform #(.W(W), .KIND(XFORM)) u_xf_held (
    .din  (out_data),
    .dout (xf_held)
  );

  rpt_count #(.D(D)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (in_cnt),
    .take     (take),
    .cnt_q    (cnt_q),
    .at_zero  (at_zero)
  );

  rpt_hold #(.W(W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .take      (take),
    .more      (~at_zero),
    .stall     (out_stall),
    .new_word  (xf_in),
    .next_word (xf_held),
    .valid_q   (out_valid),
    .data_q    (out_data)
  );
endmodule

// File: rtl/burst_repeater_chk.sv
module burst_repeater_chk #(
  parameter int W = 32,
  parameter int D = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_stall,
  input logic [D-1:0] in_cnt,
  input logic         out_valid,
  input logic         out_stall,
  input logic [W-1:0] out_data,
  input logic [D-1:0] cnt_q
);
  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !out_valid); // R1

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_stall) |=> (out_valid && cnt_q == $past(in_cnt))); // R2

  AST_BEAT_DECR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_stall && cnt_q != '0 && !in_valid)
      |=> (out_valid && cnt_q == $past(cnt_q) - 1'b1)); // R3

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stall)
      |=> (out_valid && $stable(out_data) && $stable(cnt_q))); // R4

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_stall || cnt_q != '0)) |-> in_stall); // R5

  AST_EMPTY_OPEN: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !in_stall); // R6

  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_stall && cnt_q == '0 && in_valid)
      |-> (!in_stall ##1 out_valid)); // R7

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_stall && cnt_q == '0 && !in_valid) |=> !out_valid); // R10
endmodule

bind burst_repeater burst_repeater_chk #(.W(W), .D(D)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_stall  (in_stall),
  .in_cnt    (in_cnt),
  .out_valid (out_valid),
  .out_stall (out_stall),
  .out_data  (out_data),
  .cnt_q     (cnt_q)
);

// File: tb/test_burst_repeater.sv
module test_burst_repeater;
  localparam int W = 32;
  localparam int D = 4;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // each entry: {data, count, stall density out of 16}
  localparam logic [W+D+4-1:0] VEC [NV] = '{
    {32'h0000_00A5, 4'd0,  4'd0},
    {32'h1234_5678, 4'd3,  4'd0},
    {32'hDEAD_BEEF, 4'd2,  4'd8},
    {32'hFFFF_FFFE, 4'd5,  4'd4},
    {32'h0F0F_0F0F, 4'd0,  4'd12},
    {32'h8000_0000, 4'd7,  4'd6},
    {32'h0000_0001, 4'd1,  4'd15},
    {32'hCAFE_F00D, 4'd15, 4'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] in_data = '0;
  logic [D-1:0] in_cnt = '0;
  logic in_valid = 1'b0;
  logic out_stall = 1'b0;
  logic in_stall, out_valid, in_stall_x, out_valid_x;
  logic [W-1:0] out_data, out_data_x;

  int checks = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench model
  bit hv = 1'b0;
  logic [W-1:0] cdata;
  int ccnt, idx;
  bit prev_hold = 1'b0;
  logic [W-1:0] prev_data;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_repeater #(.W(W), .D(D)) i_burst_repeater (
    .clk(clk), .rst(rst), .in_data(in_data), .in_cnt(in_cnt),
    .in_valid(in_valid), .in_stall(in_stall), .out_data(out_data),
    .out_valid(out_valid), .out_stall(out_stall)
  );

  burst_repeater #(.W(W), .D(D), .XFORM(rpt_pkg::XF_INC)) i_burst_repeater_inc (
    .clk(clk), .rst(rst), .in_data(in_data), .in_cnt(in_cnt),
    .in_valid(in_valid), .in_stall(in_stall_x), .out_data(out_data_x),
    .out_valid(out_valid_x), .out_stall(out_stall)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive after the falling edge, compare 1 unit later, before the rising edge
  task automatic cycle(input bit v, input logic [W-1:0] d, input logic [D-1:0] c,
                       input bit st, output bit accepted);
    bit exp_stall, last;
    @(negedge clk);
    in_valid = v; in_data = d; in_cnt = c; out_stall = st;
    #1;
    last = hv && (idx == ccnt);
    exp_stall = hv && !(!st && last);
    check(out_valid == hv, hv ? "R2" : "R3/R10", {31'b0, out_valid}, {31'b0, hv});
    check(out_valid_x == hv, "R2", {31'b0, out_valid_x}, {31'b0, hv});
    if (hv) begin
      check(out_data == cdata, "R8", out_data, cdata);
      check(out_data_x == cdata + W'(idx + 1), "R9", out_data_x, cdata + W'(idx + 1));
    end
    if (prev_hold)
      check(out_valid && out_data == prev_data, "R4", out_data, prev_data);
    if (!hv)
      check(in_stall == 1'b0, "R6", {31'b0, in_stall}, 32'd0);
    else if (!st && last)
      check(in_stall == 1'b0, "R7", {31'b0, in_stall}, 32'd0);
    else
      check(in_stall == 1'b1, "R5", {31'b0, in_stall}, 32'd1);
    check(in_stall_x == in_stall, "R5", {31'b0, in_stall_x}, {31'b0, in_stall});
    prev_hold = hv && st;
    prev_data = out_data;
    if (hv && !st) begin
      idx++;
      if (idx > ccnt) hv = 1'b0;
    end
    accepted = v && !exp_stall;
    if (accepted) begin
      hv = 1'b1; cdata = d; ccnt = int'(c); idx = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic drain();
    bit a;
    int guard = 0;
    while (hv && guard < 200) begin
      cycle(1'b0, '0, '0, lfsr[0] & lfsr[5], a);
      guard++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_stall = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 32'd0);
    check(in_stall == 1'b0, "R6", {31'b0, in_stall}, 32'd0);
    hv = 1'b0; prev_hold = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int low_cycles;
    int beats;
    repeat (3) @(posedge clk);
    do_reset();

    // table walk: each burst offered until taken, random stall at the entry's density
    for (int i = 0; i < NV; i++) begin
      a = 1'b0;
      while (!a)
        cycle(1'b1, VEC[i][W+8-1:8], VEC[i][7:4], lfsr[3:0] < VEC[i][3:0], a);
    end
    drain();

    // R7: zero-count words back to back, no stall: output must never go empty
    low_cycles = 0;
    for (int i = 0; i < 6; i++) begin
      cycle(1'b1, 32'h100 + i, '0, 1'b0, a);
      if (i > 0 && !out_valid) low_cycles++;
      check(a, "R7", {31'b0, a}, 32'd1);
    end
    check(low_cycles == 0, "R7", low_cycles, 0);
    drain();

    // R3: full-range count, no stall: count the beats seen
    cycle(1'b1, 32'h5A5A_0000, 4'd15, 1'b0, a);
    beats = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b0, '0, '0, 1'b0, a);
      if (out_valid) beats++;
    end
    check(beats == 16, "R3", beats, 16);

    // R4: long stall in the middle of a burst, then drain
    cycle(1'b1, 32'h0BAD_CAFE, 4'd2, 1'b0, a);
    for (int i = 0; i < 5; i++) cycle(1'b0, '0, '0, 1'b1, a);
    drain();

    // R1: reset while a burst is in progress
    cycle(1'b1, 32'h7777_7777, 4'd9, 1'b0, a);
    cycle(1'b0, '0, '0, 1'b0, a);
    do_reset();
    cycle(1'b0, '0, '0, 1'b0, a);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule